// File: doc/BRIEF.md
# Set-Associative Tag Directory

This block holds the tags and valid bits for a 4-way set-associative cache of 32 sets, each way holding one 16-word block. A 16-bit word address is split into a block tag, a set index and a word offset. The set index selects one row of the directory. The tags of all four ways in that row are compared with the address tag at the same time. In the same cycle the block reports whether the address hit, which way hit, and the lowest-numbered empty way in the row.

A fill port loads a tag into a chosen way and marks that way valid. The caller picks the way, normally the free way the lookup reported, so empty ways are used before valid blocks are evicted. A snoop port lets an agent other than the CPU drop a block after it has written that block in memory. Data storage and the victim choice for a full set sit outside this block.

Top module: `sa_tag_dir`

## Requirements
- R1: Address bits [15:9] are the tag, bits [8:4] are the set index, and bits [3:0] are the word offset. The offset never affects a lookup or a snoop.
- R2: Reset clears every valid bit. After reset every lookup misses, `lk_free` is 1 and `lk_free_way` is 0.
- R3: A way hits only when its valid bit is 1 and its stored tag equals the address tag. `lk_hit` and `lk_way` follow `lk_addr` in the same cycle, and `lk_way` is 0 on a miss.
- R4: A fill with `fill_en` high stores the tag of `fill_addr` in way `fill_way` of its set and sets that way valid. A lookup sees the new entry from the next cycle on.
- R5: A fill clears the valid bit of any other way in the same set that holds the same tag, so at most one way can hit.
- R6: `lk_free_way` is the lowest-numbered invalid way of the indexed set and `lk_free` is 1 when such a way exists. When the set is full, `lk_free` is 0 and `lk_free_way` is 0.
- R7: A snoop with `snp_en` high clears the valid bit of the way whose set and tag match `snp_addr`. All other ways and sets are left unchanged.
- R8: When a snoop and a fill address the same set in the same cycle, the snoop is applied and the fill is dropped. Operations on different sets both take effect.
- R9: A fill into a way that is already valid replaces its tag, so the old tag misses from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_addr | input | 16 | Lookup address |
| lk_hit | output | 1 | Lookup hit |
| lk_way | output | 2 | Way that hit (0 on a miss) |
| lk_free | output | 1 | Indexed set has an invalid way |
| lk_free_way | output | 2 | Lowest invalid way of the indexed set |
| fill_en | input | 1 | Fill request |
| fill_addr | input | 16 | Address of the block being loaded |
| fill_way | input | 2 | Way to load |
| snp_en | input | 1 | Snoop invalidate request |
| snp_addr | input | 16 | Address written by the external agent |

## Verification
A stale valid bit or a wrong stored tag appears as a false hit or false miss on the next lookup of that set. Because the lookup is combinational, the error shows in the first cycle after the bad write. A dropped snoop keeps the snooped address hitting. A fill that wins a snoop collision, or that leaves a duplicate tag behind, shows up as a wrong free way or a wrong hit way. The bench keeps a reference directory and compares every output on every cycle, so any divergence is caught one cycle after the edge that caused it.

// File: rtl/sa_tag_dir.sv
module sa_tag_dir #(
  parameter int ADDR_W = 16,
  parameter int OFFS_W = 4,
  parameter int SET_W  = 5,
  parameter int WAYS   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          lk_addr,
  output logic                       lk_hit,
  output logic [$clog2(WAYS)-1:0]    lk_way,
  output logic                       lk_free,
  output logic [$clog2(WAYS)-1:0]    lk_free_way,
  input  logic                       fill_en,
  input  logic [ADDR_W-1:0]          fill_addr,
  input  logic [$clog2(WAYS)-1:0]    fill_way,
  input  logic                       snp_en,
  input  logic [ADDR_W-1:0]          snp_addr
);
  localparam int TAG_W = ADDR_W - SET_W - OFFS_W;
  localparam int SETS  = 1 << SET_W;
  localparam int WAY_W = $clog2(WAYS);

  logic [TAG_W-1:0]           tag_q [SETS][WAYS];
  logic [SETS-1:0][WAYS-1:0]  vld_q;

  wire [SET_W-1:0] lk_set   = lk_addr[OFFS_W +: SET_W];
  wire [TAG_W-1:0] lk_tag   = lk_addr[ADDR_W-1 -: TAG_W];
  wire [SET_W-1:0] fill_set = fill_addr[OFFS_W +: SET_W];
  wire [TAG_W-1:0] fill_tag = fill_addr[ADDR_W-1 -: TAG_W];
  wire [SET_W-1:0] snp_set  = snp_addr[OFFS_W +: SET_W];
  wire [TAG_W-1:0] snp_tag  = snp_addr[ADDR_W-1 -: TAG_W];

  logic [WAYS-1:0] hit_vec, snp_vec, dup_vec;
  wire fill_go = fill_en && !(snp_en && snp_set == fill_set);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_vec[w] = vld_q[lk_set][w]   && tag_q[lk_set][w]   == lk_tag;
    assign snp_vec[w] = vld_q[snp_set][w]  && tag_q[snp_set][w]  == snp_tag;
    assign dup_vec[w] = vld_q[fill_set][w] && tag_q[fill_set][w] == fill_tag
                        && fill_way != WAY_W'(w);
  end

  always_comb begin
    lk_way      = '0;
    lk_free_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) lk_way = WAY_W'(w);
    for (int w = WAYS - 1; w >= 0; w--)
      if (!vld_q[lk_set][w]) lk_free_way = WAY_W'(w);
  end

  assign lk_hit  = |hit_vec;
  assign lk_free = ~&vld_q[lk_set];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      if (snp_en)
        vld_q[snp_set] <= vld_q[snp_set] & ~snp_vec;
      if (fill_go)
        vld_q[fill_set] <= (vld_q[fill_set] & ~dup_vec) | (WAYS'(1) << fill_way);
    end
  end

  always_ff @(posedge clk)
    if (fill_go) tag_q[fill_set][fill_way] <= fill_tag;

endmodule

// File: rtl/sa_tag_dir_chk.sv
module sa_tag_dir_chk #(
  parameter int ADDR_W = 16,
  parameter int OFFS_W = 4,
  parameter int SET_W  = 5,
  parameter int WAYS   = 4
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [WAYS-1:0]                 hit_vec,
  input logic [WAYS-1:0]                 snp_vec,
  input logic [(1<<SET_W)-1:0][WAYS-1:0] vld_q,
  input logic                            lk_hit,
  input logic                            lk_free,
  input logic [$clog2(WAYS)-1:0]         lk_free_way,
  input logic                            fill_en,
  input logic [ADDR_W-1:0]               fill_addr,
  input logic [$clog2(WAYS)-1:0]         fill_way,
  input logic                            snp_en,
  input logic [ADDR_W-1:0]               snp_addr
);
  localparam int WAY_W = $clog2(WAYS);

  logic              p_snp, p_fill, p_col, p_prev;
  logic [SET_W-1:0]  p_snp_set, p_fill_set;
  logic [WAYS-1:0]   p_snp_vec;
  logic [WAY_W-1:0]  p_fill_way;

  wire [SET_W-1:0] f_set = fill_addr[OFFS_W +: SET_W];
  wire [SET_W-1:0] s_set = snp_addr[OFFS_W +: SET_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_snp <= 1'b0; p_fill <= 1'b0; p_col <= 1'b0; p_prev <= 1'b0;
      p_snp_set <= '0; p_fill_set <= '0; p_snp_vec <= '0; p_fill_way <= '0;
    end else begin
      p_snp      <= snp_en;
      p_fill     <= fill_en;
      p_col      <= fill_en && snp_en && f_set == s_set;
      p_prev     <= vld_q[f_set][fill_way];
      p_snp_set  <= s_set;
      p_fill_set <= f_set;
      p_snp_vec  <= snp_vec;
      p_fill_way <= fill_way;
    end
  end

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (lk_free && lk_free_way == '0 && !lk_hit)); // R2
  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R5
  AST_FILL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (p_fill && !p_col) |-> vld_q[p_fill_set][p_fill_way]); // R4
  AST_SNOOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    p_snp |-> (vld_q[p_snp_set] & p_snp_vec) == '0); // R7
  AST_COLLIDE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    p_col |-> !(vld_q[p_fill_set][p_fill_way] && !p_prev)); // R8
endmodule

bind sa_tag_dir sa_tag_dir_chk #(
  .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .SET_W(SET_W), .WAYS(WAYS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hit_vec(hit_vec), .snp_vec(snp_vec), .vld_q(vld_q),
  .lk_hit(lk_hit), .lk_free(lk_free), .lk_free_way(lk_free_way),
  .fill_en(fill_en), .fill_addr(fill_addr), .fill_way(fill_way),
  .snp_en(snp_en), .snp_addr(snp_addr)
);

// File: tb/sa_tag_dir_tb_top.sv
module sa_tag_dir_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] lk_addr = '0, fill_addr = '0, snp_addr = '0;
  logic        fill_en = 1'b0, snp_en = 1'b0;
  logic [1:0]  fill_way = '0;
  logic        lk_hit, lk_free;
  logic [1:0]  lk_way, lk_free_way;

  int checks = 0, failures = 0;

  logic [6:0] mtag [32][4];
  logic       mvld [32][4];

  always #(CLK_PERIOD/2) clk = ~clk;

  sa_tag_dir dut_i (
    .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_way(lk_way),
    .lk_free(lk_free), .lk_free_way(lk_free_way), .fill_en(fill_en),
    .fill_addr(fill_addr), .fill_way(fill_way), .snp_en(snp_en), .snp_addr(snp_addr)
  );

  function automatic logic [15:0] mk(input int tag, input int set, input int off);
    return {7'(tag), 5'(set), 4'(off)};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input string req, input logic [15:0] la,
                      input logic fe, input logic [15:0] fa, input logic [1:0] fw,
                      input logic se, input logic [15:0] sa);
    int s, eh, ew, ef, efw;
    logic [4:0] fs, ss;
    @(negedge clk);
    lk_addr = la; fill_en = fe; fill_addr = fa; fill_way = fw;
    snp_en = se; snp_addr = sa;
    #1;
    s = la[8:4]; eh = 0; ew = 0; ef = 0; efw = 0;
    for (int w = 0; w < 4; w++)
      if (mvld[s][w] && mtag[s][w] == la[15:9]) begin eh = 1; ew = w; end
    for (int w = 3; w >= 0; w--)
      if (!mvld[s][w]) begin ef = 1; efw = w; end
    chk(req, "lk_hit", int'(lk_hit), eh);
    chk(req, "lk_way", int'(lk_way), ew);
    chk(req, "lk_free", int'(lk_free), ef);
    chk(req, "lk_free_way", int'(lk_free_way), efw);
    @(posedge clk);
    fs = fa[8:4]; ss = sa[8:4];
    if (se)
      for (int w = 0; w < 4; w++)
        if (mvld[ss][w] && mtag[ss][w] == sa[15:9]) mvld[ss][w] = 1'b0;
    if (fe && !(se && ss == fs)) begin
      for (int w = 0; w < 4; w++)
        if (w != int'(fw) && mvld[fs][w] && mtag[fs][w] == fa[15:9]) mvld[fs][w] = 1'b0;
      mvld[fs][fw] = 1'b1;
      mtag[fs][fw] = fa[15:9];
    end
  endtask

  task automatic look(input string req, input logic [15:0] a);
    step(req, a, 1'b0, '0, '0, 1'b0, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int s = 0; s < 32; s++)
      for (int w = 0; w < 4; w++) begin mvld[s][w] = 1'b0; mtag[s][w] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    look("R2", mk(0, 0, 0));
    look("R2", mk(127, 31, 15));
    // R4 and R6: fill set 3 one way at a time, free way advances
    for (int w = 0; w < 4; w++) begin
      step("R4", mk(10 + w, 3, 0), 1'b1, mk(10 + w, 3, 0), 2'(w), 1'b0, '0);
      look("R6", mk(10 + w, 3, 5));
    end
    look("R6", mk(99, 3, 0));
    look("R3", mk(12, 3, 0));
    look("R3", mk(12, 4, 0));
    look("R1", mk(13, 3, 15));
    // R7: snoop with a nonzero offset drops tag 11
    step("R7", mk(11, 3, 0), 1'b0, '0, '0, 1'b1, mk(11, 3, 9));
    look("R7", mk(11, 3, 0));
    look("R7", mk(10, 3, 0));
    // R8: collision in set 3, the fill is dropped
    step("R8", mk(10, 3, 0), 1'b1, mk(20, 3, 0), 2'd1, 1'b1, mk(10, 3, 0));
    look("R8", mk(20, 3, 0));
    look("R8", mk(10, 3, 0));
    // R8: different sets both apply
    step("R8", mk(0, 0, 0), 1'b1, mk(21, 5, 0), 2'd0, 1'b1, mk(12, 3, 0));
    look("R8", mk(21, 5, 0));
    look("R8", mk(12, 3, 0));
    // R5: duplicate tag 13 moves from way 3 to way 0
    step("R5", mk(13, 3, 0), 1'b1, mk(13, 3, 0), 2'd0, 1'b0, '0);
    look("R5", mk(13, 3, 0));
    // R9: replace way 0 tag
    step("R9", mk(13, 3, 0), 1'b1, mk(40, 3, 0), 2'd0, 1'b0, '0);
    look("R9", mk(13, 3, 0));
    look("R9", mk(40, 3, 0));
    // random mix, small tag and set pools to force hits and collisions
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] la, fa, sa;
      logic fe, se;
      logic [1:0] fw;
      la = mk($urandom % 6, $urandom % 3, $urandom % 16);
      fa = mk($urandom % 6, $urandom % 3, $urandom % 16);
      sa = mk($urandom % 6, $urandom % 3, $urandom % 16);
      fe = ($urandom % 3) == 0;
      se = ($urandom % 5) == 0;
      fw = 2'($urandom);
      step("R3/R6", la, fe, fa, fw, se, sa);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule